// File: doc/BRIEF.md
# Configuration Access and Security Controller

This block sits between a test or programming port and the configuration store of a programmable logic device. A requester issues one command per cycle on a simple valid/opcode/address/data interface. The commands program a configuration word, read a configuration word back, force one output register to a chosen level, write or read one byte of a 64-bit user signature, set the security bit, or erase everything.

The security bit can be written only once. It takes effect on the very next command. From then on, configuration read-back, configuration programming and register preload are refused. A refused command answers with an error flag, returns zero data and changes nothing. The user signature stays readable and writable whatever the security state. Only a full erase clears the security bit, and the same erase also wipes the configuration store and the signature. Every command is answered one cycle later with a single-cycle done pulse that carries the error flag and any read data.

Top module: `cfg_access_ctrl`

## Requirements
- R1: After reset, rsp_done, rsp_err, rsp_data and reg_q are all zero, the configuration store and the signature hold zero, and the device is unsecured.
- R2: A command presented with cmd_valid high in cycle N gives rsp_done high in cycle N+1 only. rsp_done is low in any cycle that follows a cycle without cmd_valid.
- R3: When unsecured, opcode 1 (program) stores cmd_wdata at word cmd_addr, and opcode 2 (verify) returns that word in rsp_data with rsp_err low.
- R4: Opcode 6 (secure) sets the security bit, and the bit governs the command in the very next cycle. The bit stays set until an erase.
- R5: A verify issued while secured returns rsp_err high and rsp_data zero.
- R6: A preload or program issued while secured returns rsp_err high and rsp_data zero, and reg_q is unchanged.
- R7: When unsecured, opcode 3 (preload) sets bit cmd_addr of reg_q to cmd_wdata[0] and leaves the other bits alone. A preload index of NREG or more returns an error and changes nothing.
- R8: Opcode 4 writes cmd_wdata[7:0] to signature byte cmd_addr[2:0], and opcode 5 returns that byte zero-extended in rsp_data. Neither opcode ever reports an error, secured or not.
- R9: Opcode 7 (erase) clears the configuration store, the signature and the security bit, and leaves reg_q unchanged.
- R10: Every response that is not a successful verify or a signature read carries zero data. Opcode 0 answers done with no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 program, 2 verify, 3 preload, 4 signature write, 5 signature read, 6 secure, 7 erase |
| cmd_addr | input | ADDR_W (4) | Word address, register index or signature byte index |
| cmd_wdata | input | DATA_W (8) | Write data; bit 0 is the preload level |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | DATA_W (8) | Read data, zero unless a read succeeded |
| reg_q | output | NREG (8) | Output register state |

## Verification
The hardest case to reach is the boundary around the security bit. A secure command must be followed in the very next cycle by a verify or preload that is already refused. The bit must then survive arbitrary traffic, and an erase must release it in exactly one step. The stimulus builds this case directly: back-to-back secure and blocked commands, signature traffic while secured, and then an erase followed at once by read-backs. A long randomized run then mixes rare secure and erase commands into ordinary traffic, so that the sticky state is entered and left many times.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_PROG    = 3'd1,
      OP_VERIFY  = 3'd2,
      OP_PRELOAD = 3'd3,
      OP_SIG_WR  = 3'd4,
      OP_SIG_RD  = 3'd5,
      OP_SECURE  = 3'd6,
      OP_ERASE   = 3'd7
   } acc_op_e;
endpackage

// File: rtl/word_bank.sv
module word_bank #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);
   generate
      if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
         $error("word_bank: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("word_bank: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

   // R3
   bank_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> (mem[$past(addr)] == $past(wdata)));

   // R9
   bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rdata == '0));
endmodule

// File: rtl/preload_bank.sv
module preload_bank #(
   parameter int NREG = 8,
   localparam int IW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_en,
   input  logic [IW-1:0]   ld_idx,
   input  logic            ld_val,
   output logic [NREG-1:0] q
);
   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("preload_bank: NREG must be at least 2");
      end
      for (genvar g = 0; g < NREG; g++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[g] <= 1'b0;
            else if (ld_en && (ld_idx == IW'(g))) q[g] <= ld_val;
         end
      end
   endgenerate

   // R7
   one_bit_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(q ^ $past(q)) <= 1));

   // R6
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(q));
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
   import cfg_access_pkg::*;
#(
   parameter int CFG_DEPTH = 16,
   parameter int DATA_W    = 8,
   parameter int NREG      = 8,
   parameter int SIG_BYTES = 8,
   localparam int CFG_AW   = $clog2(CFG_DEPTH),
   localparam int SIG_AW   = $clog2(SIG_BYTES),
   localparam int PL_AW    = $clog2(NREG),
   localparam int AW_A     = (CFG_AW > SIG_AW) ? CFG_AW : SIG_AW,
   localparam int ADDR_W   = (AW_A > PL_AW) ? AW_A : PL_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_data,
   output logic [NREG-1:0]   reg_q
);
   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("cfg_access_ctrl: DATA_W must hold a signature byte");
      end
   endgenerate

   acc_op_e           op;
   logic              secured_q;
   logic              pl_in_range;
   logic              gated;
   logic              cfg_we, sig_we, pl_en, erase;
   logic [DATA_W-1:0] cfg_rdata;
   logic [7:0]        sig_rdata;
   logic              nxt_err;
   logic [DATA_W-1:0] nxt_data;

   assign op          = acc_op_e'(cmd_op);
   assign pl_in_range = ({1'b0, cmd_addr} < (ADDR_W + 1)'(NREG));
   assign gated       = secured_q &&
                        (op == OP_PROG || op == OP_VERIFY || op == OP_PRELOAD);
   assign erase       = cmd_valid && (op == OP_ERASE);
   assign cfg_we      = cmd_valid && (op == OP_PROG) && !secured_q;
   assign sig_we      = cmd_valid && (op == OP_SIG_WR);
   assign pl_en       = cmd_valid && (op == OP_PRELOAD) && !secured_q && pl_in_range;

   word_bank #(.DEPTH(CFG_DEPTH), .WIDTH(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .clr(erase), .wr_en(cfg_we),
      .addr(cmd_addr[CFG_AW-1:0]), .wdata(cmd_wdata), .rdata(cfg_rdata));

   word_bank #(.DEPTH(SIG_BYTES), .WIDTH(8)) u_sig (
      .clk(clk), .rst_n(rst_n), .clr(erase), .wr_en(sig_we),
      .addr(cmd_addr[SIG_AW-1:0]), .wdata(cmd_wdata[7:0]), .rdata(sig_rdata));

   preload_bank #(.NREG(NREG)) u_pl (
      .clk(clk), .rst_n(rst_n), .ld_en(pl_en),
      .ld_idx(cmd_addr[PL_AW-1:0]), .ld_val(cmd_wdata[0]), .q(reg_q));

   always_comb begin
      nxt_err  = gated || ((op == OP_PRELOAD) && !pl_in_range);
      nxt_data = '0;
      if (!nxt_err) begin
         if (op == OP_VERIFY)      nxt_data = cfg_rdata;
         else if (op == OP_SIG_RD) nxt_data = DATA_W'(sig_rdata);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secured_q <= 1'b0;
         rsp_done  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         if (erase) secured_q <= 1'b0;
         else if (cmd_valid && op == OP_SECURE) secured_q <= 1'b1;
         rsp_done <= cmd_valid;
         rsp_err  <= cmd_valid && nxt_err;
         rsp_data <= cmd_valid ? nxt_data : '0;
      end
   end

   // R2
   done_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_done);
   // R2
   no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_done);
   // R4
   secure_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (secured_q && !erase) |=> secured_q);
   // R5
   verify_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_VERIFY && secured_q) |=> (rsp_err && rsp_data == '0));
   // R6
   preload_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_PRELOAD && secured_q) |=> (rsp_err && $stable(reg_q)));
   // R8
   sig_always_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (op == OP_SIG_RD || op == OP_SIG_WR)) |=> !rsp_err);
   // R10
   err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_data == '0));
endmodule

// File: tb/cfg_access_ctrl_test.sv
module cfg_access_ctrl_test;
   import cfg_access_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int NR    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [3:0] cmd_addr = '0;
   logic [7:0] cmd_wdata = '0;
   logic       rsp_done, rsp_err;
   logic [7:0] rsp_data;
   logic [7:0] reg_q;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   // behavioural model state
   int m_cfg [DEPTH];
   int m_sig [8];
   bit m_sec;
   bit m_regs [NR];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_access_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_done(rsp_done),
      .rsp_err(rsp_err), .rsp_data(rsp_data), .reg_q(reg_q));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int regs_word();
      int w = 0;
      for (int i = 0; i < NR; i++) if (m_regs[i]) w |= (1 << i);
      return w;
   endfunction

   // drive one command at a negedge, update the model, compare at the next negedge
   task automatic issue(input int op, input int addr, input int wd);
      int    e_err = 0;
      int    e_data = 0;
      string tag = "R10";
      cmd_valid = 1'b1;
      cmd_op    = 3'(op);
      cmd_addr  = 4'(addr);
      cmd_wdata = 8'(wd);
      case (op)
         1: begin
            if (m_sec) begin e_err = 1; tag = "R6"; end
            else begin m_cfg[addr] = wd; tag = "R3"; end
         end
         2: begin
            if (m_sec) begin e_err = 1; tag = "R5"; end
            else begin e_data = m_cfg[addr]; tag = "R3"; end
         end
         3: begin
            if (m_sec) begin e_err = 1; tag = "R6"; end
            else if (addr >= NR) begin e_err = 1; tag = "R7"; end
            else begin m_regs[addr] = wd[0]; tag = "R7"; end
         end
         4: begin m_sig[addr % 8] = wd; tag = "R8"; end
         5: begin e_data = m_sig[addr % 8]; tag = "R8"; end
         6: begin m_sec = 1; tag = "R4"; end
         7: begin
            for (int i = 0; i < DEPTH; i++) m_cfg[i] = 0;
            for (int i = 0; i < 8; i++) m_sig[i] = 0;
            m_sec = 0;
            tag = "R9";
         end
         default: tag = "R10";
      endcase
      @(negedge clk);
      cmd_valid = 1'b0;
      check(rsp_done === 1'b1, "R2", "done", int'(rsp_done), 1);
      check(rsp_err === 1'(e_err), tag, "err", int'(rsp_err), e_err);
      check(rsp_data === 8'(e_data), tag, "data", int'(rsp_data), e_data);
      check(reg_q === 8'(regs_word()), tag, "regs", int'(reg_q), regs_word());
   endtask

   task automatic idle();
      cmd_valid = 1'b0;
      @(negedge clk);
      check(rsp_done === 1'b0, "R2", "idle done", int'(rsp_done), 0);
      check(reg_q === 8'(regs_word()), "R2", "idle regs", int'(reg_q), regs_word());
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) m_cfg[i] = 0;
      for (int i = 0; i < 8; i++) m_sig[i] = 0;
      for (int i = 0; i < NR; i++) m_regs[i] = 0;
      m_sec = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(rsp_done === 1'b0, "R1", "reset done", int'(rsp_done), 0);
      check(rsp_err === 1'b0, "R1", "reset err", int'(rsp_err), 0);
      check(rsp_data === 8'h00, "R1", "reset data", int'(rsp_data), 0);
      check(reg_q === 8'h00, "R1", "reset regs", int'(reg_q), 0);
      rst_n = 1'b1;
      @(negedge clk);
      issue(2, 0, 0);        // R1 unsecured, store empty
      issue(5, 3, 0);        // R1 signature empty
      // R3 program and verify
      issue(1, 0, 8'hA5);
      issue(1, 15, 8'h3C);
      issue(2, 0, 0);
      issue(2, 15, 0);
      issue(0, 0, 0);        // R10
      // R8 signature
      for (int i = 0; i < 8; i++) issue(4, i, 8'h10 + i);
      issue(5, 7, 0);
      issue(5, 8, 0);        // upper address bit ignored
      // R7 preload
      issue(3, 0, 1);
      issue(3, 7, 1);
      issue(3, 3, 8'hFF);
      issue(3, 0, 0);
      issue(3, 9, 1);        // out of range
      // R4 immediate effect, R5/R6 refusals
      issue(6, 0, 0);
      issue(2, 0, 0);
      issue(3, 1, 1);
      issue(1, 2, 8'h77);
      idle();
      idle();
      issue(5, 7, 0);        // R8 still readable
      issue(4, 2, 8'hEE);
      issue(5, 2, 0);
      issue(6, 0, 0);
      issue(2, 15, 0);       // R4 still set
      // R9 erase
      issue(7, 0, 0);
      issue(2, 0, 0);
      issue(2, 15, 0);
      issue(5, 2, 0);
      issue(3, 5, 1);
      // mixed traffic
      for (int n = 0; n < 2000; n++) begin
         int r = int'($urandom % 32);
         if (r == 2) idle();
         else if (r == 0) issue(6, 0, 0);
         else if (r == 1) issue(7, 0, 0);
         else issue(r % 6, int'($urandom % 16), int'($urandom % 256));
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule